// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Lookaside Cache

The block turns a processor's virtual address into a physical address. The upper bits of the virtual address are the virtual page number and the lower `PAGE_BITS` bits are the page offset, so a page is a power of two in size. A small fully associative lookaside cache of page-table entries is searched first. If the page is there, the physical address comes back with no memory traffic. If it is not, the block reads the entry from a single-level page table in memory. The address of that entry is a base register plus the virtual page number scaled by the entry size.

A fetched entry whose valid bit is set produces a physical address and is written into the cache. A clear valid bit makes the block answer with a fault flag and no address. A faulting entry is never cached.

Requests use a valid/ready handshake. A request is taken on any edge where `req_valid` and `req_ready` are both high. The requester must hold `req_vaddr` stable while `req_valid` is high and `req_ready` is low. Only one translation is open at a time: `req_ready` falls for the whole duration of a table read, and that is the only back-pressure the block applies. Responses are a one-cycle `rsp_valid` pulse with no ready, so the requester must always take them. The memory port has a one-cycle request pulse and takes a later response pulse, with no flow control on either side.

Top module: `mmu_xlate`

## Requirements
- R1: The physical address is the page number from the entry (entry bits [PPN_W:1]) in the upper bits, followed by the offset bits of the virtual address `req_vaddr[PAGE_BITS-1:0]`, passed through unchanged.
- R2: The table read address is `base + (vpn << PTE_SHIFT)`, taken modulo 2^PA_W, where `vpn = req_vaddr[VA_W-1:PAGE_BITS]`. If the base is written on the same edge that a request is accepted, the new base is used.
- R3: Entry bit 0 is the valid bit. When it is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0.
- R4: On a cache hit, `rsp_valid` is high in the cycle right after acceptance, and no table read is issued.
- R5: On a miss, `mem_req_valid` pulses for exactly one cycle, in the cycle after acceptance. `rsp_valid` follows in the cycle after `mem_rsp_valid` is sampled. Exactly one table read is made per miss.
- R6: `req_ready` is low from the cycle after a missing request is accepted until the table response has been taken. It is high again in the cycle where `rsp_valid` is high.
- R7: A valid fetched entry is cached, so the next access to that page hits. A faulting entry is not cached, so a retry reads the table again.
- R8: A fill takes the lowest-numbered free slot. When no slot is free, a round-robin pointer picks the victim. The pointer starts at slot 0 and advances by one for each victim it picks, wrapping at `TLB_DEPTH`.
- R9: A `tlb_flush` pulse empties the cache in one cycle. A request accepted in the same cycle as the pulse is treated as a miss.
- R10: A write of `base_wdata` with `base_wr` loads the base register and also empties the cache.
- R11: A flush or base write that arrives while a table read is open still lets that read answer, but the fetched entry is not cached.
- R12: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Entry was not valid |
| base_wr | input | 1 | Load the base register and flush the cache |
| base_wdata | input | PA_W | New page-table base address |
| tlb_flush | input | 1 | Invalidate every cache slot |
| mem_req_valid | output | 1 | Table read strobe |
| mem_req_addr | output | PA_W | Table entry address |
| mem_rsp_valid | input | 1 | Table read data present |
| mem_rsp_data | input | PPN_W+1 | Table entry: page number above a valid bit |

## Verification
The bench sweeps every virtual page of a small configuration twice in a row. This exposes a design that caches faulting entries: its retry would hit with stale data and skip the second table read. A capacity sequence runs with more pages than slots, and every hit, miss and table address is predicted from a reference model of the free-first, round-robin victim rule. A design with a pointer that moves on free fills, or that evicts the wrong slot, would show hits and misses in the wrong places.

Flushes are placed three ways: on their own, on the same edge as an accepted request, and in the middle of a table read. These catch a lookup that still hits after a flush, and a walk that refills the cache with an entry fetched before the flush. A base change is checked both for the address of the next table read and for the flush it implies.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/mmu_victim.sv
module mmu_victim #(
  parameter int DEPTH = 128,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] slot_vld,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest free slot wins: scan downward so the last hit is the lowest index
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance && !any_free) begin
      if (rr_q == IDX_W'(DEPTH - 1)) rr_q <= '0;
      else                           rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int DEPTH = 128,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  logic [DEPTH-1:0] vld_q;
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic [IDX_W-1:0] victim;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end
  endgenerate

  // a page sits in at most one slot, so an OR of masked entries selects it
  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < DEPTH; i++) begin
      lk_ppn = lk_ppn | (ppn_q[i] & {PPN_W{match[i]}});
    end
  end
  assign lk_hit = |match;

  mmu_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_vld(vld_q),
    .advance (fill_en && !flush),
    .victim  (victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
    end
  end
endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
  import mmu_pkg::*;
#(
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int PA_W      = 32,
  parameter int PTE_SHIFT = 2,
  parameter int PTE_W     = PPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [PA_W-1:0]  base,
  input  logic             flush_evt,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic             done_fault,
  output logic [PPN_W-1:0] done_ppn,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn
);
  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PA_W-1:0]  addr_q;
  logic             stale_q;
  logic [PA_W-1:0]  entry_addr;

  assign entry_addr = base + (PA_W'(start_vpn) << PTE_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      vpn_q   <= '0;
      addr_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          if (start) begin
            state_q <= WK_ISSUE;
            vpn_q   <= start_vpn;
            addr_q  <= entry_addr;
            stale_q <= 1'b0;
          end
        end
        WK_ISSUE: begin
          state_q <= WK_WAIT;
          stale_q <= stale_q | flush_evt;
        end
        WK_WAIT: begin
          stale_q <= stale_q | flush_evt;
          if (mem_rsp_valid) state_q <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == WK_ISSUE);
  assign mem_req_addr  = addr_q;
  assign busy          = (state_q != WK_IDLE);
  assign done          = (state_q == WK_WAIT) && mem_rsp_valid;
  assign done_fault    = !mem_rsp_data[0];
  assign done_ppn      = mem_rsp_data[PPN_W:1];
  assign fill_en       = done && mem_rsp_data[0] && !stale_q && !flush_evt;
  assign fill_vpn      = vpn_q;
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_SHIFT = 2,
  parameter int TLB_DEPTH = 128,
  parameter logic [PA_W-1:0] BASE_RESET = '0,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS,
  localparam int PTE_W = PPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  input  logic             base_wr,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             tlb_flush,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  logic [PA_W-1:0]      base_q;
  logic [PA_W-1:0]      base_eff;
  logic                 flush_evt;
  logic                 accept;
  logic                 hit_now;
  logic [VPN_W-1:0]     lk_vpn;
  logic                 lk_hit;
  logic [PPN_W-1:0]     lk_ppn;
  logic [PAGE_BITS-1:0] off_q;
  logic                 busy;
  logic                 done;
  logic                 done_fault;
  logic [PPN_W-1:0]     done_ppn;
  logic                 fill_en;
  logic [VPN_W-1:0]     fill_vpn;

  assign flush_evt = tlb_flush || base_wr;
  assign base_eff  = base_wr ? base_wdata : base_q;
  assign lk_vpn    = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign hit_now   = lk_hit && !flush_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= BASE_RESET;
    else if (base_wr) base_q <= base_wdata;
  end

  mmu_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .DEPTH(TLB_DEPTH)) i_tlb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_evt),
    .lk_vpn  (lk_vpn),
    .lk_hit  (lk_hit),
    .lk_ppn  (lk_ppn),
    .fill_en (fill_en),
    .fill_vpn(fill_vpn),
    .fill_ppn(done_ppn)
  );

  mmu_walker #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W), .PTE_SHIFT(PTE_SHIFT), .PTE_W(PTE_W)
  ) i_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept && !hit_now),
    .start_vpn    (lk_vpn),
    .base         (base_eff),
    .flush_evt    (flush_evt),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .busy         (busy),
    .done         (done),
    .done_fault   (done_fault),
    .done_ppn     (done_ppn),
    .fill_en      (fill_en),
    .fill_vpn     (fill_vpn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      off_q     <= '0;
    end else begin
      rsp_valid <= (accept && hit_now) || done;
      if (accept) off_q <= req_vaddr[PAGE_BITS-1:0];
      if (accept && hit_now) begin
        rsp_paddr <= {lk_ppn, req_vaddr[PAGE_BITS-1:0]};
        rsp_fault <= 1'b0;
      end else if (done) begin
        rsp_paddr <= done_fault ? '0 : {done_ppn, off_q};
        rsp_fault <= done_fault;
      end
    end
  end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_req_valid,
  input logic            mem_rsp_valid
);
  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R5
  AST_WALK_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R6
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R3
  AST_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_req_valid)); // R4
  AST_WALK_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_req_valid && mem_rsp_valid) |=> rsp_valid); // R5
  AST_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R6
endmodule

bind mmu_xlate mmu_xlate_chk #(.PA_W(PA_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_paddr    (rsp_paddr),
  .mem_req_valid(mem_req_valid),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_mmu_xlate.sv
`timescale 1ns/1ps
module test_mmu_xlate;
  localparam int VA_W = 12, PA_W = 12, PB = 4, SH = 1, DEPTH = 4, LAT = 2;
  localparam int VPN_W = VA_W - PB, PPN_W = PA_W - PB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, base_wr = 1'b0, tlb_flush = 1'b0, mem_rsp_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [PA_W-1:0] base_wdata = '0;
  logic [PPN_W:0]  mem_rsp_data = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_req_valid;
  logic [PA_W-1:0] rsp_paddr, mem_req_addr;

  always #10 clk = ~clk;

  mmu_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .PTE_SHIFT(SH), .TLB_DEPTH(DEPTH))
  i_mmu_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .base_wr(base_wr), .base_wdata(base_wdata),
    .tlb_flush(tlb_flush), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_fail = 0, mem_cnt = 0;
  logic [PA_W-1:0] last_addr = '0;

  // reference cache state
  bit             m_vld [DEPTH];
  int             m_tag [DEPTH];
  int             m_ppn [DEPTH];
  int             m_rr = 0;
  int             m_base = 0;

  function automatic logic [PPN_W:0] mem_fn(int addr);
    int idx = addr >> 1;
    logic v = ((idx * 5 + 3) % 7) != 0;
    logic [PPN_W-1:0] p = PPN_W'((idx * 13 + 7) % 256);
    return {p, v};
  endfunction

  function automatic int ent_addr(int base, int vpn);
    return (base + (vpn << SH)) % (1 << PA_W);
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic m_flush();
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
  endtask

  task automatic m_fill(int vpn, int ppn);
    int slot = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % DEPTH;
    end
    m_vld[slot] = 1'b1; m_tag[slot] = vpn; m_ppn[slot] = ppn;
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        mem_cnt++;
        last_addr = mem_req_addr;
        repeat (LAT) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_fn(int'(last_addr));
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // one translation; called and returns at a negedge
  task automatic xlate(int vpn, int off, bit fl_same, bit fl_mid, string ctx);
    logic [VA_W-1:0] va = VA_W'((vpn << PB) | off);
    int mc0 = mem_cnt, cyc = 1, ea, hit_ppn = 0;
    bit hit = 1'b0;
    logic [PPN_W:0] pte;
    if (fl_same) m_flush();
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_tag[i] == vpn) begin hit = 1'b1; hit_ppn = m_ppn[i]; end
    ea  = ent_addr(m_base, vpn);
    pte = mem_fn(ea);
    req_valid = 1'b1; req_vaddr = va; tlb_flush = fl_same;
    @(negedge clk);
    req_valid = 1'b0; tlb_flush = 1'b0;
    while (!rsp_valid && cyc < 40) begin
      if (cyc == 1 && fl_mid) tlb_flush = 1'b1;
      chk(!req_ready, {ctx, " R6 ready low in walk"}, req_ready, 0);
      @(negedge clk);
      tlb_flush = 1'b0;
      cyc++;
    end
    chk(rsp_valid, {ctx, " R5 response seen"}, rsp_valid, 1);
    chk(req_ready, {ctx, " R6 ready with response"}, req_ready, 1);
    if (hit) begin
      chk(cyc == 1, {ctx, " R4 hit latency"}, cyc, 1);
      chk(mem_cnt == mc0, {ctx, " R4 no table read on hit"}, mem_cnt - mc0, 0);
      chk(rsp_paddr == PA_W'((hit_ppn << PB) | off) && !rsp_fault,
          {ctx, " R1 hit paddr"}, rsp_paddr, (hit_ppn << PB) | off);
    end else begin
      chk(cyc == 2 + LAT, {ctx, " R5 miss latency"}, cyc, 2 + LAT);
      chk(mem_cnt == mc0 + 1, {ctx, " R5 one table read"}, mem_cnt - mc0, 1);
      chk(int'(last_addr) == ea, {ctx, " R2 entry address"}, last_addr, ea);
      chk(rsp_fault == !pte[0], {ctx, " R3 fault flag"}, rsp_fault, !pte[0]);
      if (pte[0])
        chk(rsp_paddr == PA_W'((int'(pte[PPN_W:1]) << PB) | off),
            {ctx, " R1 walk paddr"}, rsp_paddr, (int'(pte[PPN_W:1]) << PB) | off);
      else
        chk(rsp_paddr == '0, {ctx, " R3 fault paddr zero"}, rsp_paddr, 0);
      if (fl_mid) m_flush();
      else if (pte[0]) m_fill(vpn, int'(pte[PPN_W:1]));
    end
    @(negedge clk);
    chk(!rsp_valid, {ctx, " R5 single response pulse"}, rsp_valid, 0);
  endtask

  task automatic set_base(int b);
    base_wr = 1'b1; base_wdata = PA_W'(b);
    @(negedge clk);
    base_wr = 1'b0;
    m_base = b; m_flush();
  endtask

  function automatic int nth_valid(int base, int n);
    int seen = 0;
    for (int v = 0; v < (1 << VPN_W); v++)
      if (mem_fn(ent_addr(base, v))[0]) begin
        if (seen == n) return v;
        seen++;
      end
    return 0;
  endfunction

  function automatic int nth_fault(int base, int n);
    int seen = 0;
    for (int v = 0; v < (1 << VPN_W); v++)
      if (!mem_fn(ent_addr(base, v))[0]) begin
        if (seen == n) return v;
        seen++;
      end
    return 0;
  endfunction

  initial begin
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R12 reset ready", req_ready, 1);
    chk(!rsp_valid, "R12 reset rsp_valid", rsp_valid, 0);
    chk(!mem_req_valid, "R12 reset mem_req_valid", mem_req_valid, 0);
    // first access after reset must miss (empty cache); base resets to 0
    xlate(3, 5, 0, 0, "R12 empty");

    // R7 sweep: every page twice; valid pages hit, faulting pages re-read
    set_base(12'h100);
    for (int v = 0; v < (1 << VPN_W); v++) begin
      xlate(v, (v * 3) & 15, 0, 0, "R7 sweep1");
      xlate(v, (v * 7 + 1) & 15, 0, 0, "R7 sweep2");
    end
    begin
      int fv = nth_fault(12'h100, 0);
      xlate(fv, 1, 0, 0, "R7 fault retry");
      xlate(fv, 2, 0, 0, "R7 fault retry again");
    end

    // R8 capacity: DEPTH+2 pages cycled, free-first then round robin
    tlb_flush = 1'b1; @(negedge clk); tlb_flush = 1'b0; m_flush();
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < DEPTH + 2; k++) xlate(nth_valid(12'h100, k), k, 0, 0, "R8 evict");
    for (int k = 0; k < DEPTH; k++) xlate(nth_valid(12'h100, DEPTH - 1 - k), 9, 0, 0, "R8 reverse");

    // R9 flush alone and on the acceptance edge
    xlate(nth_valid(12'h100, 0), 4, 0, 0, "R9 warm");
    xlate(nth_valid(12'h100, 0), 4, 0, 0, "R9 warm hit");
    tlb_flush = 1'b1; @(negedge clk); tlb_flush = 1'b0; m_flush();
    xlate(nth_valid(12'h100, 0), 6, 0, 0, "R9 after flush");
    xlate(nth_valid(12'h100, 0), 7, 1, 0, "R9 same-edge flush");
    xlate(nth_valid(12'h100, 0), 8, 0, 0, "R9 refilled");

    // R10 base change: new addresses and implied flush
    set_base(12'h340);
    xlate(nth_valid(12'h100, 0), 2, 0, 0, "R10 new base");
    xlate(nth_valid(12'h340, 1), 3, 0, 0, "R10 new base b");
    xlate(nth_valid(12'h340, 1), 3, 0, 0, "R10 new base hit");

    // R11 flush while a table read is open: answered but not cached
    xlate(nth_valid(12'h340, 5), 10, 0, 1, "R11 mid flush");
    xlate(nth_valid(12'h340, 5), 11, 0, 0, "R11 re-read");
    xlate(nth_valid(12'h340, 5), 12, 0, 0, "R11 now cached");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule